// File: doc/BRIEF.md
# Prefixed Burst Transfer Sequencer

This block moves 32-bit longs, 16-bit words and single bytes between a small word-indexed local register RAM and a shared, byte-addressed main memory. A transfer command names a direction, a size, a local register index and a main-memory byte address. An optional prefix command, issued immediately before a long transfer, supplies a repeat value Q. The long transfer then becomes a burst of Q+1 beats in which the register index and the memory address both step upward. The issuing core is stalled through `busy` for the whole transfer. Between an accepted prefix and the transfer that uses it, `irq_inhibit` keeps interrupts off so the pair cannot be split.

Main-memory addresses need no alignment. An access whose bytes straddle a 32-bit word boundary is carried out as two word accesses, with byte strobes on writes. During a burst the local RAM read port is moved away from the command's register. After the last beat the sequencer spends one more cycle pointing the read port back at that register, so its value is current again when the core resumes. Single transfers do not take this cycle.

Top module: `lburst_seq`

## Requirements
- R1: A prefix (cmd_op 1) carrying Q, followed by a long read (cmd_op 2, cmd_size 2 or 3), writes Q+1 local registers. Beat i loads the long at byte address A+4i into register (R+i) modulo the RAM depth.
- R2: A prefix carrying Q, followed by a long write (cmd_op 3), stores local register (R+i) modulo depth to byte addresses A+4i..A+4i+3 for i = 0..Q.
- R3: A transfer consumes the pending Q. A later transfer without a prefix, or any transfer with Q = 0, moves exactly one item.
- R4: A byte (cmd_size 0) or word (cmd_size 1) transfer that follows a prefix moves one item and still consumes the prefix.
- R5: Any byte address is allowed. Byte k of an access goes to main-memory word (A+k)>>2, lane (A+k)&3. mem_wstrb bit j enables byte lane j (bits 8j+7..8j). An access that crosses a word boundary makes two memory accesses, lower word first.
- R6: Byte and word reads are zero-extended to 32 bits in the local RAM. Byte and word writes enable only the addressed lanes.
- R7: irq_inhibit is 1 from the cycle after a prefix is accepted until the cycle after the following transfer is accepted, and is then 0.
- R8: A command is accepted only while busy is 0, and commands presented while busy have no effect. With memory granting in the cycle of request, a read stays busy one cycle per memory access and a write one cycle more per beat.
- R9: After a burst (Q > 0) there is exactly one extra busy cycle with no memory request, in which ram_raddr equals the command's register index. Single transfers have no such cycle.
- R10: While mem_req is 1 and mem_gnt is 0, mem_req, mem_addr and mem_we hold their values.
- R11: After reset busy, irq_inhibit, mem_req and ram_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when not busy |
| cmd_op | input | 2 | 0 none, 1 prefix, 2 read, 3 write |
| cmd_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| cmd_reg | input | REG_AW | Local register index |
| cmd_addr | input | ADDR_W | Main-memory byte address |
| cmd_q | input | Q_W | Repeat value carried by a prefix |
| busy | output | 1 | Stall to the issuing core |
| irq_inhibit | output | 1 | Interrupts blocked while a prefix is pending |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-2 | Main-memory word address |
| mem_wdata | output | 32 | Write data, lane aligned |
| mem_wstrb | output | 4 | Byte lane enables |
| mem_gnt | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read word, valid with mem_gnt |
| ram_raddr | output | REG_AW | Local RAM read address |
| ram_rdata | input | 32 | Local RAM read data, one cycle after address |
| ram_we | output | 1 | Local RAM write enable |
| ram_waddr | output | REG_AW | Local RAM write address |
| ram_wdata | output | 32 | Local RAM write data |

## Verification
The bench targets bursts that start two registers below the top of the RAM and wrap to zero. A design that does not wrap the index, or that steps the address by one byte, writes the wrong registers. Unaligned longs, and words at lane 3, must split into two accesses with the correct strobes and lane order; a swapped or unsplit access shows up as corrupted bytes. It also checks that a prefix before a byte read, or a pending Q, does not leak into the next transfer. It checks that the re-read cycle appears after bursts only, that a prefix presented while busy does nothing, and that a memory that stalls every other cycle yields the same data.

// File: rtl/lburst_pkg.sv
package lburst_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PREFIX = 2'd1,
        OP_READ   = 2'd2,
        OP_WRITE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LO,
        S_HI,
        S_REREAD
    } seq_state_e;

    localparam int LANES = 4;

    function automatic logic [LANES-1:0] lane_mask(size_e sz);
        case (sz)
            SZ_BYTE: return 4'b0001;
            SZ_WORD: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] byte_expand(logic [LANES-1:0] m);
        logic [31:0] r;
        for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{m[i]}};
        return r;
    endfunction

endpackage

// File: rtl/bst_prefix_hold.sv
module bst_prefix_hold #(
    parameter int Q_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           set_i,
    input  logic [Q_W-1:0] q_i,
    input  logic           take_i,
    output logic [Q_W-1:0] q_o,
    output logic           armed_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o     <= '0;
            armed_o <= 1'b0;
        end else if (set_i) begin
            q_o     <= q_i;
            armed_o <= 1'b1;
        end else if (take_i) begin
            q_o     <= '0;
            armed_o <= 1'b0;
        end
    end

    AST_PREFIX_ARMS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> armed_o && (q_o == $past(q_i)));  // R7

    AST_PREFIX_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (take_i && !set_i) |=> !armed_o && (q_o == '0));  // R3

endmodule

// File: rtl/bst_lane_unit.sv
module bst_lane_unit
    import lburst_pkg::*;
(
    input  logic [1:0]  off_i,
    input  size_e       size_i,
    input  logic [31:0] wdata_i,
    input  logic [31:0] lo_i,
    input  logic [31:0] hi_i,
    output logic [31:0] wlo_o,
    output logic [31:0] whi_o,
    output logic [3:0]  slo_o,
    output logic [3:0]  shi_o,
    output logic        spans_o,
    output logic [31:0] rdval_o
);

    logic [3:0]  mask;
    logic [4:0]  shamt;
    logic [63:0] wide_w;
    logic [7:0]  wide_s;
    logic [63:0] raw;

    always_comb begin
        mask    = lane_mask(size_i);
        shamt   = {off_i, 3'b000};
        wide_w  = {32'h0, wdata_i} << shamt;
        wide_s  = {4'h0, mask} << off_i;
        raw     = {hi_i, lo_i} >> shamt;
        wlo_o   = wide_w[31:0];
        whi_o   = wide_w[63:32];
        slo_o   = wide_s[3:0];
        shi_o   = wide_s[7:4];
        spans_o = |wide_s[7:4];
        rdval_o = raw[31:0] & byte_expand(mask);
    end

endmodule

// File: rtl/lburst_seq.sv
module lburst_seq
    import lburst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_AW = 9,
    parameter int Q_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_size,
    input  logic [REG_AW-1:0] cmd_reg,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [Q_W-1:0]    cmd_q,
    output logic              busy,
    output logic              irq_inhibit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic [REG_AW-1:0] ram_raddr,
    input  logic [31:0]       ram_rdata,
    output logic              ram_we,
    output logic [REG_AW-1:0] ram_waddr,
    output logic [31:0]       ram_wdata
);

    localparam int WADDR_W = ADDR_W - 2;

    typedef struct packed {
        logic              wr;
        size_e             size;
        logic [REG_AW-1:0] rix;
        logic [ADDR_W-1:0] addr;
        logic [Q_W-1:0]    left;
        logic              burst;
    } job_t;

    seq_state_e        state;
    job_t              job;
    logic [REG_AW-1:0] home_reg;
    logic [31:0]       lo_q;

    op_e               op;
    logic              accept, take, set_q, armed, spans, beat_end;
    logic [Q_W-1:0]    q_val, start_left;
    logic [31:0]       lo_word, hi_word, wr_lo, wr_hi, rd_val;
    logic [3:0]        strb_lo, strb_hi;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && (state == S_IDLE);
    assign take   = accept && ((op == OP_READ) || (op == OP_WRITE));
    assign set_q  = accept && (op == OP_PREFIX);
    assign start_left = (cmd_size[1] && armed) ? q_val : '0;

    bst_prefix_hold #(.Q_W(Q_W)) u_pfx (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_q),
        .q_i     (cmd_q),
        .take_i  (take),
        .q_o     (q_val),
        .armed_o (armed)
    );

    assign lo_word = (state == S_HI) ? lo_q : mem_rdata;
    assign hi_word = (state == S_HI) ? mem_rdata : 32'h0;

    bst_lane_unit u_lane (
        .off_i   (job.addr[1:0]),
        .size_i  (job.size),
        .wdata_i (ram_rdata),
        .lo_i    (lo_word),
        .hi_i    (hi_word),
        .wlo_o   (wr_lo),
        .whi_o   (wr_hi),
        .slo_o   (strb_lo),
        .shi_o   (strb_hi),
        .spans_o (spans),
        .rdval_o (rd_val)
    );

    assign beat_end = mem_gnt && (((state == S_LO) && !spans) || (state == S_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            job      <= '0;
            home_reg <= '0;
            lo_q     <= '0;
        end else begin
            case (state)
                S_IDLE: if (take) begin
                    job.wr    <= (op == OP_WRITE);
                    job.size  <= size_e'(cmd_size);
                    job.rix   <= cmd_reg;
                    job.addr  <= cmd_addr;
                    job.left  <= start_left;
                    job.burst <= (start_left != '0);
                    home_reg  <= cmd_reg;
                    state     <= (op == OP_WRITE) ? S_FETCH : S_LO;
                end
                S_FETCH: state <= S_LO;
                S_LO, S_HI: begin
                    if (mem_gnt && (state == S_LO) && spans) begin
                        lo_q  <= mem_rdata;
                        state <= S_HI;
                    end else if (beat_end) begin
                        if (job.left == '0) begin
                            state <= job.burst ? S_REREAD : S_IDLE;
                        end else begin
                            job.left <= job.left - 1'b1;
                            job.rix  <= job.rix + 1'b1;
                            job.addr <= job.addr + ADDR_W'(4);
                            state    <= job.wr ? S_FETCH : S_LO;
                        end
                    end
                end
                S_REREAD: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    assign busy        = (state != S_IDLE);
    assign irq_inhibit = armed;
    assign mem_req     = (state == S_LO) || (state == S_HI);
    assign mem_we      = job.wr;
    assign mem_addr    = job.addr[ADDR_W-1:2] + WADDR_W'((state == S_HI) ? 1 : 0);
    assign mem_wdata   = (state == S_HI) ? wr_hi : wr_lo;
    assign mem_wstrb   = (state == S_HI) ? strb_hi : strb_lo;
    assign ram_raddr   = ((state == S_FETCH) || mem_req) ? job.rix : home_reg;
    assign ram_we      = !job.wr && beat_end;
    assign ram_waddr   = job.rix;
    assign ram_wdata   = rd_val;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we));  // R10

    AST_TAKE_STALLS: assert property (@(posedge clk) disable iff (rst)
        take |=> busy);  // R8

    AST_REREAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == S_REREAD) |-> !mem_req && !ram_we && (ram_raddr == home_reg));  // R9

    AST_STRB_LIVE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wstrb != 4'h0));  // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !ram_we);  // R11

endmodule

// File: tb/lburst_seq_bench.sv
module lburst_seq_bench;

    localparam int ADDR_W = 16;
    localparam int REG_AW = 9;
    localparam int Q_W    = 9;
    localparam int DEPTH  = 1 << REG_AW;

    typedef struct {
        bit          is_mem;
        int          idx;
        logic [31:0] data;
        logic [3:0]  strb;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [1:0]        cmd_size = 2'd0;
    logic [REG_AW-1:0] cmd_reg = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [Q_W-1:0]    cmd_q = '0;
    logic              busy, irq_inhibit, mem_req, mem_we, mem_gnt, ram_we;
    logic [ADDR_W-3:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata, ram_rdata, ram_wdata;
    logic [3:0]        mem_wstrb;
    logic [REG_AW-1:0] ram_raddr, ram_waddr;

    logic [31:0] mainm [256];
    logic [31:0] lram [DEPTH];
    logic        slow = 1'b0;
    logic        tick = 1'b0;
    item_t       sb[$];
    string       cur_tag = "R11";
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    lburst_seq #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .Q_W(Q_W)) u_lburst_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_size(cmd_size), .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_q(cmd_q),
        .busy(busy), .irq_inhibit(irq_inhibit), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .ram_raddr(ram_raddr),
        .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata)
    );

    // memory models: main memory grants at once, or every other cycle when slow
    assign mem_rdata = mainm[mem_addr[7:0]];
    assign mem_gnt   = mem_req && (!slow || tick);

    always @(posedge clk) begin
        tick <= ~tick;
        if (mem_req && mem_we && mem_gnt)
            for (int j = 0; j < 4; j++)
                if (mem_wstrb[j]) mainm[mem_addr[7:0]][8*j +: 8] <= mem_wdata[8*j +: 8];
        if (ram_we) lram[ram_waddr] <= ram_wdata;
        ram_rdata <= lram[ram_raddr];
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(string req, bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(logic [3:0] s);
        logic [31:0] r;
        for (int j = 0; j < 4; j++) r[8*j +: 8] = {8{s[j]}};
        return r;
    endfunction

    function automatic logic [7:0] mbyte(int a);
        return mainm[(a >> 2) & 255][8*(a & 3) +: 8];
    endfunction

    // monitor: pops the scoreboard for every write the design produces
    task automatic sb_pop(bit is_mem, int idx, logic [31:0] d, logic [3:0] s);
        item_t e;
        if (sb.size() == 0) begin
            check(cur_tag, 1'b0, "unexpected write", idx, -1);
            return;
        end
        e = sb.pop_front();
        check(cur_tag, e.is_mem == is_mem, "write kind", is_mem, e.is_mem);
        check(cur_tag, e.idx == idx, "write index", idx, e.idx);
        if (is_mem) begin
            check(cur_tag, e.strb == s, "byte strobes", s, e.strb);
            check(cur_tag, (d & lanes(e.strb)) == (e.data & lanes(e.strb)),
                  "memory data", d & lanes(e.strb), e.data & lanes(e.strb));
        end else begin
            check(cur_tag, d == e.data, "register data", d, e.data);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we) sb_pop(1'b0, int'(ram_waddr), ram_wdata, 4'hf);
            if (mem_req && mem_we && mem_gnt) sb_pop(1'b1, int'(mem_addr), mem_wdata, mem_wstrb);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R8 watchdog: actual %0d cycles expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    // driver: pushes expected writes, issues the command, holds it while stalled
    task automatic run_xfer(string tag, bit wr, int sz, int r, int a, bit pre, int q, bit poke);
        int   n        = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        int   beats    = (pre && sz >= 2) ? q + 1 : 1;
        bit   burst    = (beats > 1);
        int   acc      = (((a & 3) + n) > 4) ? 2 : 1;
        int   exp_busy = beats * (acc + (wr ? 1 : 0)) + (burst ? 1 : 0);
        int   cnt      = 0;
        int   last_ra  = -1;
        item_t it;
        cur_tag = tag;
        for (int b = 0; b < beats; b++) begin
            int          ba;
            int          w0;
            logic [31:0] src;
            logic [31:0] dat [2];
            logic [3:0]  stb [2];
            ba = a + 4*b;
            if (wr) begin
                src = lram[(r + b) % DEPTH];
                w0  = ba >> 2;
                dat[0] = '0; dat[1] = '0; stb[0] = '0; stb[1] = '0;
                for (int k = 0; k < n; k++) begin
                    int wi;
                    int ln;
                    wi = ((ba + k) >> 2) - w0;
                    ln = (ba + k) & 3;
                    stb[wi][ln] = 1'b1;
                    dat[wi][8*ln +: 8] = src[8*k +: 8];
                end
                it.is_mem = 1'b1; it.idx = w0; it.data = dat[0]; it.strb = stb[0];
                sb.push_back(it);
                if (stb[1] != 4'h0) begin
                    it.idx = w0 + 1; it.data = dat[1]; it.strb = stb[1];
                    sb.push_back(it);
                end
            end else begin
                src = '0;
                for (int k = 0; k < n; k++) src[8*k +: 8] = mbyte(ba + k);
                it.is_mem = 1'b0; it.idx = (r + b) % DEPTH; it.data = src; it.strb = 4'hf;
                sb.push_back(it);
            end
        end
        if (pre) begin
            cmd_op = 2'd1; cmd_q = Q_W'(q); cmd_valid = 1'b1;
            @(negedge clk);
            check("R7", irq_inhibit == 1'b1, "inhibit after prefix", irq_inhibit, 1);
        end
        cmd_op = wr ? 2'd3 : 2'd2; cmd_size = 2'(sz);
        cmd_reg = REG_AW'(r); cmd_addr = ADDR_W'(a); cmd_valid = 1'b1;
        @(negedge clk);
        if (pre) check("R7", irq_inhibit == 1'b0, "inhibit after transfer", irq_inhibit, 0);
        while (busy) begin
            cnt++;
            last_ra = int'(ram_raddr);
            if (poke && cnt == 1) begin
                cmd_op = 2'd1; cmd_q = 7;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        if (!slow) check("R8", cnt == exp_busy, "busy cycles", cnt, exp_busy);
        if (burst) check("R9", last_ra == r, "re-read register", last_ra, r);
        if (poke) check("R8", irq_inhibit == 1'b0, "prefix while busy ignored", irq_inhibit, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mainm[i] = 32'h9E3779B9 * (i + 1);
        for (int i = 0; i < DEPTH; i++) lram[i] = 32'h5A000000 + i * 32'h00010203;
        repeat (3) @(negedge clk);
        check("R11", busy == 1'b0, "busy in reset", busy, 0);
        check("R11", irq_inhibit == 1'b0, "inhibit in reset", irq_inhibit, 0);
        check("R11", mem_req == 1'b0, "mem_req in reset", mem_req, 0);
        check("R11", ram_we == 1'b0, "ram_we in reset", ram_we, 0);
        rst = 1'b0;
        @(negedge clk);

        run_xfer("R3", 1'b0, 2, 5,   'h40,  1'b0, 0, 1'b0);  // single aligned long
        run_xfer("R6", 1'b0, 0, 6,   'h43,  1'b0, 0, 1'b0);  // byte, zero-extended
        run_xfer("R6", 1'b0, 1, 7,   'h45,  1'b0, 0, 1'b0);  // word
        run_xfer("R5", 1'b0, 1, 8,   'h47,  1'b0, 0, 1'b0);  // word across boundary
        run_xfer("R5", 1'b0, 2, 9,   'h81,  1'b0, 0, 1'b0);  // unaligned long
        run_xfer("R1", 1'b0, 2, 510, 'h102, 1'b1, 3, 1'b0);  // burst read, wraps index
        run_xfer("R3", 1'b0, 2, 12,  'h60,  1'b0, 0, 1'b0);  // Q consumed
        run_xfer("R4", 1'b0, 0, 13,  'h71,  1'b1, 4, 1'b0);  // prefix then byte
        run_xfer("R4", 1'b0, 2, 14,  'h74,  1'b0, 0, 1'b0);  // prefix gone
        run_xfer("R3", 1'b0, 2, 15,  'h90,  1'b1, 0, 1'b0);  // Q=0 single, no re-read
        run_xfer("R2", 1'b1, 2, 7,   'h200, 1'b0, 0, 1'b0);  // single write long
        run_xfer("R6", 1'b1, 0, 8,   'h205, 1'b0, 0, 1'b0);  // byte write
        run_xfer("R6", 1'b1, 1, 9,   'h20B, 1'b0, 0, 1'b0);  // word write across boundary
        run_xfer("R2", 1'b1, 2, 100, 'h223, 1'b1, 5, 1'b0);  // unaligned burst write
        run_xfer("R1", 1'b0, 2, 300, 'h223, 1'b1, 5, 1'b0);  // read it back
        run_xfer("R2", 1'b1, 2, 509, 'h2F0, 1'b1, 4, 1'b0);  // write burst wraps index
        slow = 1'b1;
        run_xfer("R10", 1'b0, 2, 20, 'h31,  1'b1, 2, 1'b0);
        run_xfer("R10", 1'b1, 2, 20, 'h301, 1'b1, 2, 1'b0);
        slow = 1'b0;
        run_xfer("R8", 1'b0, 2, 40, 'h50, 1'b0, 0, 1'b1);    // prefix offered while busy
        run_xfer("R8", 1'b0, 2, 41, 'h54, 1'b0, 0, 1'b0);    // must stay single
        repeat (4) @(negedge clk);
        check("R1", sb.size() == 0, "scoreboard drained", sb.size(), 0);
        summary();
        $finish;
    end

endmodule